// File: doc/BRIEF.md
# Windowed Multichannel Sample Accumulator

This block keeps a running signed total for each of four current-sense channels. Every valid input beat carries one 8-bit two's-complement sample per channel. Each channel adds its sample into a private accumulator. Once a programmable number of beats has been taken, all four totals are copied together into snapshot registers. A ready flag marks the copy, and then a fresh window starts on its own with the accumulators at zero.

A host reaches the block through a command strobe carrying an 8-bit code. One code restarts the current window. Four other codes each return one channel's snapshot, zero-extended to 24 bits, one clock after the strobe. The host divides a snapshot by the window length to get an average, and it converts that average to a current itself. The block also presents a per-channel gain-select status word, which the host needs for that conversion.

Top module: `win_accum_top`

## Requirements
- R1: After reset, the ready flag, the response valid flag, the response data and the gain status are all zero, and every channel read returns zero.
- R2: Each snapshot holds the two's-complement sum of that channel's 8-bit signed samples over one window, 20 bits wide. Code 0x71 reads channel 1, 0x72 channel 2, 0x73 channel 3 and 0x74 channel 4.
- R3: The ready flag is low while samples are still being taken. It goes high in the cycle after the window's last sample is accepted and stays high for exactly two cycles.
- R4: Samples offered while the ready flag is high are ignored. The next window starts automatically after the ready flag falls, with every accumulator at zero.
- R5: Code 0x70 clears all accumulators and the sample count, so that a full new window follows. It drops the ready flag in the next cycle and leaves the snapshots unchanged. A sample offered in the same cycle as 0x70 is discarded.
- R6: Every command strobe produces exactly one response-valid pulse in the following cycle. Responses are 24 bits wide, and bits 23..20 are zero.
- R7: Any code other than 0x70..0x74 returns zero data and changes neither the window count nor the snapshots.
- R8: All four snapshots change in the same cycle, and only while the ready flag is high. A read strobed during the ready window returns either the complete previous sum or the complete new sum.
- R9: Gain status bit i (bit 0 = channel 1) follows gain-select input bit i one cycle later. A 1 means gain 8 and a 0 means gain 4.
- R10: A window length of 0 acts as 1. A length of 4096 full-scale samples (-128 or +127) does not overflow the 20-bit sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_len_i | input | 13 | Window length in samples (0 treated as 1) |
| smp_vld_i | input | 1 | Sample beat valid for all channels |
| smp_i | input | 32 | Channel samples, channel 1 in bits 7..0 up to channel 4 in bits 31..24 |
| gain8_sel_i | input | 4 | Per-channel gain-8 select, bit 0 = channel 1 |
| cmd_stb_i | input | 1 | Command strobe |
| cmd_code_i | input | 8 | Command code |
| rsp_vld_o | output | 1 | Response valid, one cycle after the strobe |
| rsp_data_o | output | 24 | Response data, zero-extended |
| snap_rdy_o | output | 1 | New snapshot ready flag |
| gain_stat_o | output | 4 | Registered gain-select status |

## Verification
A sample counter that is off by one shows up at once: the ready flag rises one beat early or late relative to the bench's count of accepted samples. An accumulator that is not cleared, or a sample that leaks in during the hold or the restart cycle, shows up as a wrong sum on the first read after that window. Reads strobed in both ready cycles expose a torn or skewed snapshot copy in the very next cycle, because the data must match either the whole old total or the whole new one.

// File: rtl/win_accum_pkg.sv
package win_accum_pkg;

    localparam int DEF_NUM_CH   = 4;
    localparam int DEF_SAMPLE_W = 8;
    localparam int DEF_MAX_WIN  = 4096;
    localparam int DEF_CMD_W    = 8;
    localparam int DEF_RSP_W    = 24;

    localparam logic [7:0] CMD_RESTART = 8'h70;
    localparam logic [7:0] CMD_RD_BASE = 8'h71;

    typedef enum logic [1:0] {
        SEQ_ACC   = 2'd0,
        SEQ_LATCH = 2'd1,
        SEQ_HOLD  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/win_seq.sv
module win_seq
    import win_accum_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] win_len,
    input  logic             smp_vld,
    input  logic             restart,
    output logic             acc_en,
    output logic             acc_clr,
    output logic             snap_load,
    output logic             rdy
);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        last_idx  = (win_len == '0) ? '0 : win_len - CNT_W'(1);
        seq_d     = seq_q;
        acc_en    = 1'b0;
        acc_clr   = 1'b0;
        snap_load = 1'b0;
        if (restart) begin
            seq_d.st  = SEQ_ACC;
            seq_d.cnt = '0;
            acc_clr   = 1'b1;
        end else begin
            case (seq_q.st)
                SEQ_ACC: begin
                    if (smp_vld) begin
                        acc_en = 1'b1;
                        if (seq_q.cnt >= last_idx) begin
                            seq_d.st  = SEQ_LATCH;
                            seq_d.cnt = '0;
                        end else begin
                            seq_d.cnt = seq_q.cnt + CNT_W'(1);
                        end
                    end
                end
                SEQ_LATCH: begin
                    snap_load = 1'b1;
                    seq_d.st  = SEQ_HOLD;
                end
                SEQ_HOLD: begin
                    acc_clr  = 1'b1;
                    seq_d.st = SEQ_ACC;
                end
                default: begin
                    seq_d.st  = SEQ_ACC;
                    seq_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_ACC, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rdy = (seq_q.st != SEQ_ACC);

endmodule

// File: rtl/win_lane.sv
module win_lane #(
    parameter int SAMPLE_W = 8,
    parameter int ACC_W    = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                clr,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [ACC_W-1:0]    snap
);

    localparam int EXT_W = ACC_W - SAMPLE_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] snap;
    } lane_regs_t;

    lane_regs_t lane_d, lane_q;
    logic [ACC_W-1:0] smp_ext;

    always_comb begin
        smp_ext = {{EXT_W{sample[SAMPLE_W-1]}}, sample};
        lane_d  = lane_q;
        if (clr) begin
            lane_d.acc = '0;
        end else if (en) begin
            lane_d.acc = lane_q.acc + smp_ext;
        end
        if (load) begin
            lane_d.snap = lane_q.acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign snap = lane_q.snap;

endmodule

// File: rtl/win_cmd_port.sv
module win_cmd_port
    import win_accum_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ACC_W  = 20,
    parameter int CMD_W  = 8,
    parameter int RSP_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_stb,
    input  logic [CMD_W-1:0]        cmd_code,
    input  logic [NUM_CH*ACC_W-1:0] snap_flat,
    output logic                    restart,
    output logic                    rsp_vld,
    output logic [RSP_W-1:0]        rsp_data
);

    typedef struct packed {
        logic             vld;
        logic [RSP_W-1:0] data;
    } rsp_regs_t;

    rsp_regs_t rsp_d, rsp_q;

    always_comb begin
        restart    = cmd_stb && (cmd_code == CMD_W'(CMD_RESTART));
        rsp_d.vld  = cmd_stb;
        rsp_d.data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cmd_stb && (cmd_code == CMD_W'(int'(CMD_RD_BASE) + i))) begin
                rsp_d.data = RSP_W'(snap_flat[i*ACC_W +: ACC_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_vld  = rsp_q.vld;
    assign rsp_data = rsp_q.data;

endmodule

// File: rtl/win_accum_top.sv
module win_accum_top
    import win_accum_pkg::*;
#(
    parameter int NUM_CH   = DEF_NUM_CH,
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int MAX_WIN  = DEF_MAX_WIN,
    parameter int CMD_W    = DEF_CMD_W,
    parameter int RSP_W    = DEF_RSP_W,
    localparam int ACC_W   = SAMPLE_W + $clog2(MAX_WIN),
    localparam int CNT_W   = $clog2(MAX_WIN + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           win_len_i,
    input  logic                       smp_vld_i,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_i,
    input  logic [NUM_CH-1:0]          gain8_sel_i,
    input  logic                       cmd_stb_i,
    input  logic [CMD_W-1:0]           cmd_code_i,
    output logic                       rsp_vld_o,
    output logic [RSP_W-1:0]           rsp_data_o,
    output logic                       snap_rdy_o,
    output logic [NUM_CH-1:0]          gain_stat_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] gain;
    } top_regs_t;

    top_regs_t top_d, top_q;

    logic                    restart;
    logic                    acc_en;
    logic                    acc_clr;
    logic                    snap_load;
    logic [NUM_CH*ACC_W-1:0] snap_flat;

    win_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_len   (win_len_i),
        .smp_vld   (smp_vld_i),
        .restart   (restart),
        .acc_en    (acc_en),
        .acc_clr   (acc_clr),
        .snap_load (snap_load),
        .rdy       (snap_rdy_o)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        win_lane #(
            .SAMPLE_W (SAMPLE_W),
            .ACC_W    (ACC_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (acc_en),
            .clr    (acc_clr),
            .load   (snap_load),
            .sample (smp_i[ch*SAMPLE_W +: SAMPLE_W]),
            .snap   (snap_flat[ch*ACC_W +: ACC_W])
        );
    end

    win_cmd_port #(
        .NUM_CH (NUM_CH),
        .ACC_W  (ACC_W),
        .CMD_W  (CMD_W),
        .RSP_W  (RSP_W)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_stb   (cmd_stb_i),
        .cmd_code  (cmd_code_i),
        .snap_flat (snap_flat),
        .restart   (restart),
        .rsp_vld   (rsp_vld_o),
        .rsp_data  (rsp_data_o)
    );

    always_comb begin
        top_d      = top_q;
        top_d.gain = gain8_sel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign gain_stat_o = top_q.gain;

endmodule

// File: rtl/win_accum_chk.sv
module win_accum_chk #(
    parameter int NUM_CH = 4,
    parameter int ACC_W  = 20,
    parameter int CMD_W  = 8,
    parameter int RSP_W  = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_stb_i,
    input logic [CMD_W-1:0]        cmd_code_i,
    input logic                    rsp_vld_o,
    input logic [RSP_W-1:0]        rsp_data_o,
    input logic                    snap_rdy_o,
    input logic [NUM_CH*ACC_W-1:0] snap_flat,
    input logic [NUM_CH-1:0]       gain8_sel_i,
    input logic [NUM_CH-1:0]       gain_stat_o
);

    logic is_restart;
    logic is_read;

    assign is_restart = cmd_stb_i && (cmd_code_i == CMD_W'(8'h70));
    assign is_read    = (cmd_code_i >= CMD_W'(8'h71)) &&
                        (cmd_code_i <  CMD_W'(8'h71 + NUM_CH));

    AST_RDY_SECOND_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snap_rdy_o) && !is_restart |=> snap_rdy_o);                        // R3

    AST_RDY_DROPS_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        snap_rdy_o && $past(snap_rdy_o) |=> !snap_rdy_o);                        // R3

    AST_RESTART_CLEARS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        is_restart |=> !snap_rdy_o);                                             // R5

    AST_RSP_FOLLOWS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_i |=> rsp_vld_o);                                                // R6

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb_i |=> !rsp_vld_o);                                              // R6

    AST_RSP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld_o |-> (rsp_data_o[RSP_W-1:ACC_W] == '0));                        // R6

    AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_i && !is_read |=> (rsp_data_o == '0));                           // R7

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_rdy_o |=> $stable(snap_flat));                                     // R8

    AST_GAIN_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (gain_stat_o == $past(gain8_sel_i)));                          // R9

endmodule

bind win_accum_top win_accum_chk #(
    .NUM_CH (NUM_CH),
    .ACC_W  (ACC_W),
    .CMD_W  (CMD_W),
    .RSP_W  (RSP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_stb_i   (cmd_stb_i),
    .cmd_code_i  (cmd_code_i),
    .rsp_vld_o   (rsp_vld_o),
    .rsp_data_o  (rsp_data_o),
    .snap_rdy_o  (snap_rdy_o),
    .snap_flat   (snap_flat),
    .gain8_sel_i (gain8_sel_i),
    .gain_stat_o (gain_stat_o)
);

// File: tb/tb_win_accum_top.sv
`timescale 1ns/1ps
module tb_win_accum_top;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] win_len = 13'd5;
    logic        smp_vld = 1'b0;
    logic [31:0] smp = '0;
    logic [3:0]  gain_sel = '0;
    logic        cmd_stb = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic        rsp_vld;
    logic [23:0] rsp_data;
    logic        snap_rdy;
    logic [3:0]  gain_stat;

    always #2.5 clk = ~clk;

    win_accum_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_len_i   (win_len),
        .smp_vld_i   (smp_vld),
        .smp_i       (smp),
        .gain8_sel_i (gain_sel),
        .cmd_stb_i   (cmd_stb),
        .cmd_code_i  (cmd_code),
        .rsp_vld_o   (rsp_vld),
        .rsp_data_o  (rsp_data),
        .snap_rdy_o  (snap_rdy),
        .gain_stat_o (gain_stat)
    );

    typedef struct {
        logic [23:0] alt_a;
        logic [23:0] alt_b;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    int  run_sum[NCH];
    int  exp_snap[NCH];

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] ext(int s);
        return {4'h0, 20'(s)};
    endfunction

    function automatic int sval(int seed, int c, int k);
        if (seed < 0) return (c % 2 == 0) ? -128 : 127;
        return ((k * 37 + c * 53 + seed * 11 + k * k * seed) % 256) - 128;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_vld) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R6 unexpected response", 32'(rsp_data), 32'h0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(rsp_data == it.alt_a || rsp_data == it.alt_b, it.tag,
                      32'(rsp_data), 32'(it.alt_a));
            end
        end
    end

    task automatic rd(logic [7:0] code, logic [23:0] a, logic [23:0] b, string tag);
        @(negedge clk);
        sb_q.push_back('{alt_a: a, alt_b: b, tag: tag});
        cmd_stb  = 1'b1;
        cmd_code = code;
        @(negedge clk);
        cmd_stb  = 1'b0;
    endtask

    task automatic read_all(string tag);
        for (int c = 0; c < NCH; c++)
            rd(8'h71 + 8'(c), ext(exp_snap[c]), ext(exp_snap[c]), tag);
    endtask

    task automatic push_smp(int seed, int k);
        @(negedge clk);
        check(snap_rdy == 1'b0, "R3 ready low while sampling", 32'(snap_rdy), 32'h0);
        smp_vld = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            int v;
            v = sval(seed, c, k);
            smp[c*8 +: 8] = 8'(v);
            run_sum[c] += v;
        end
    endtask

    // cycles after the last sample: A (ready), B (ready), then idle
    task automatic finish_window(bit junk, bit rd_hold);
        @(negedge clk);
        smp_vld = junk;
        smp = 32'h7F7F7F7F;
        check(snap_rdy == 1'b1, "R3 ready first cycle", 32'(snap_rdy), 32'h1);
        if (rd_hold) begin
            sb_q.push_back('{alt_a: ext(exp_snap[0]), alt_b: ext(run_sum[0]),
                             tag: "R8 read in first ready cycle"});
            cmd_stb = 1'b1; cmd_code = 8'h71;
        end
        @(negedge clk);
        smp = 32'h80808080;
        check(snap_rdy == 1'b1, "R3 ready second cycle", 32'(snap_rdy), 32'h1);
        if (rd_hold) begin
            sb_q.push_back('{alt_a: ext(exp_snap[3]), alt_b: ext(run_sum[3]),
                             tag: "R8 read in second ready cycle"});
            cmd_stb = 1'b1; cmd_code = 8'h74;
        end
        @(negedge clk);
        cmd_stb = 1'b0;
        smp_vld = 1'b0;
        check(snap_rdy == 1'b0, "R3 ready drops after two", 32'(snap_rdy), 32'h0);
        for (int c = 0; c < NCH; c++) exp_snap[c] = run_sum[c];
    endtask

    task automatic window(int seed, int n, bit gaps, bit junk, bit rd_hold);
        for (int c = 0; c < NCH; c++) run_sum[c] = 0;
        for (int k = 0; k < n; k++) begin
            if (gaps && (k % 3 == 1)) begin
                @(negedge clk);
                smp_vld = 1'b0;
            end
            push_smp(seed, k);
        end
        finish_window(junk, rd_hold);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin run_sum[c] = 0; exp_snap[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(snap_rdy == 1'b0, "R1 ready after reset", 32'(snap_rdy), 32'h0);
        check(rsp_vld == 1'b0, "R1 rsp valid after reset", 32'(rsp_vld), 32'h0);
        check(rsp_data == 24'h0, "R1 rsp data after reset", 32'(rsp_data), 32'h0);
        check(gain_stat == 4'h0, "R1 gain after reset", 32'(gain_stat), 32'h0);
        read_all("R1 snapshot zero after reset");

        // R2 R3 R6: basic window, then reads
        window(1, 5, 0, 0, 0);
        read_all("R2 R6 window sum");
        // R2 with idle gaps and another length
        win_len = 13'd7;
        window(2, 7, 1, 0, 0);
        read_all("R2 gapped window sum");

        // R4: junk during ready ignored, automatic restart
        window(3, 7, 0, 1, 0);
        window(4, 7, 0, 0, 0);
        read_all("R4 auto restart, hold samples ignored");

        // R8: reads during the ready window
        window(5, 7, 0, 0, 1);
        read_all("R8 snapshot after load");

        // R5: restart mid-window
        win_len = 13'd5;
        for (int c = 0; c < NCH; c++) run_sum[c] = 0;
        for (int k = 0; k < 3; k++) push_smp(6, k);
        @(negedge clk);
        sb_q.push_back('{alt_a: 24'h0, alt_b: 24'h0, tag: "R5 restart returns zero"});
        smp_vld = 1'b1;
        smp = 32'h7F7F7F7F;
        cmd_stb = 1'b1;
        cmd_code = 8'h70;
        @(negedge clk);
        cmd_stb = 1'b0;
        smp_vld = 1'b0;
        check(snap_rdy == 1'b0, "R5 ready low after restart", 32'(snap_rdy), 32'h0);
        read_all("R5 snapshots kept across restart");
        window(7, 5, 0, 0, 0);
        read_all("R5 full window after restart");

        // R5: restart during the ready window drops the flag
        for (int c = 0; c < NCH; c++) run_sum[c] = 0;
        for (int k = 0; k < 5; k++) push_smp(8, k);
        @(negedge clk);
        smp_vld = 1'b0;
        sb_q.push_back('{alt_a: 24'h0, alt_b: 24'h0, tag: "R5 restart in ready"});
        cmd_stb = 1'b1;
        cmd_code = 8'h70;
        check(snap_rdy == 1'b1, "R3 ready before restart", 32'(snap_rdy), 32'h1);
        @(negedge clk);
        cmd_stb = 1'b0;
        check(snap_rdy == 1'b0, "R5 ready cleared by restart", 32'(snap_rdy), 32'h0);
        read_all("R5 aborted load keeps old snapshot");

        // R7: unknown codes mid-window
        for (int c = 0; c < NCH; c++) run_sum[c] = 0;
        for (int k = 0; k < 2; k++) push_smp(9, k);
        @(negedge clk);
        smp_vld = 1'b0;
        rd(8'h00, 24'h0, 24'h0, "R7 code 00");
        rd(8'h6F, 24'h0, 24'h0, "R7 code 6F");
        rd(8'h75, 24'h0, 24'h0, "R7 code 75");
        rd(8'hFF, 24'h0, 24'h0, "R7 code FF");
        read_all("R7 snapshots untouched");
        for (int k = 2; k < 5; k++) push_smp(9, k);
        finish_window(0, 0);
        read_all("R7 count not reset");

        // R9 gain status
        @(negedge clk);
        gain_sel = 4'b1010;
        @(negedge clk);
        check(gain_stat == 4'b1010, "R9 gain status", 32'(gain_stat), 32'hA);
        gain_sel = 4'b0101;
        @(negedge clk);
        check(gain_stat == 4'b0101, "R9 gain status", 32'(gain_stat), 32'h5);

        // R10 length zero acts as one
        win_len = 13'd0;
        window(10, 1, 0, 0, 0);
        read_all("R10 zero length window");
        // R10 full-scale maximum window
        win_len = 13'd4096;
        window(-1, 4096, 0, 0, 0);
        check(exp_snap[0] == -524288, "R10 model min sum", 32'(exp_snap[0]), 32'hFFF80000);
        read_all("R10 max window no overflow");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R6 all responses seen", 32'(sb_q.size()), 32'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule